// File: doc/BRIEF.md
# Carrier Mark/Space Modulator Gate

This block shapes a transmit waveform. Each modulation cycle has a mark phase and then a space phase. In time mode the output follows an externally generated carrier during the mark and is held low during the space. In baseband mode the output is held high for the whole mark. Cycles repeat back to back for as long as the block is enabled.

All durations are counted in ticks. A tick is one period of the module clock divided by eight. The mark lasts one tick more than the value in its 16-bit register. The space lasts exactly the value in its 16-bit register, and that value may be zero. Both registers are sampled only at the start of a cycle. The space value is held in an internal shadow copy, so writes made during a cycle take effect in the next one. At 8 MHz one tick is 1 µs, so either phase can reach about 65.5 ms.

Every completed cycle sets a sticky end-of-cycle flag. A one-cycle clear strobe clears it. The interrupt request is the flag gated by an enable. When the block is disabled, the cycle in progress runs to its end before the output drops and the counters return to idle, whatever the mark length is compared with the carrier high time. All pins are plain control and status signals; the block has no streaming interface and therefore no back-pressure.

Top module: `carrier_modulator`

## Requirements
- R1: Phase changes happen only on tick edges. Tick edges fall every 8 clock cycles, counted from the clock edge at which the block starts a cycle.
- R2: The mark of a cycle lasts (mark_val + 1) × 8 clock cycles. The value used is the one sampled at the start of that cycle.
- R3: The space lasts space_val × 8 clock cycles. With a sampled value of 0 there is no space, and the next mark follows the previous mark directly.
- R4: Time mode (baseband = 0): during the mark, mod_out equals carrier_in. Otherwise mod_out is 0.
- R5: Baseband mode (baseband = 1): mod_out is 1 for the whole mark and 0 otherwise.
- R6: Changes to mark_val and space_val during a cycle do not affect that cycle. They apply from the next cycle start.
- R7: eoc_flag goes to 1 on the clock edge that ends a cycle. That edge is the end of the space, or the end of the mark when the sampled space is 0. irq equals eoc_flag AND eoc_ie.
- R8: eoc_flag stays set until eoc_clr is sampled high. If a cycle ends on the same edge as the clear, the set wins.
- R9: When en is low at the end of a cycle, the block goes idle and mod_out stays 0. When en is high while idle, a new cycle starts with a mark on the next edge.
- R10: While rst_n is low, mod_out, eoc_flag and irq are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Modulator enable |
| baseband | input | 1 | 1 selects baseband mode, 0 selects time mode |
| carrier_in | input | 1 | Carrier from the external generator |
| mark_val | input | 16 | Mark length register (ticks minus one) |
| space_val | input | 16 | Space length register (ticks) |
| eoc_ie | input | 1 | End-of-cycle interrupt enable |
| eoc_clr | input | 1 | Write-one-to-clear strobe for the flag |
| mod_out | output | 1 | Gated modulator output |
| eoc_flag | output | 1 | Sticky end-of-cycle flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that en, baseband, mark_val, space_val and eoc_clr change only between clock edges, and that eoc_clr is a single-cycle strobe. The stimulus meets this by changing every input just after a rising edge. Register values are rewritten in the middle of cycles, including zero space and zero mark. This checks that the sampled copies, not the live inputs, set the durations.

// File: rtl/cmg_pkg.sv
package cmg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_MARK  = 2'd1,
    PH_SPACE = 2'd2
  } cmg_phase_e;
endpackage

// File: rtl/cmg_prescaler.sv
module cmg_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV > 1) begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      localparam logic [PW-1:0] ONE  = PW'(1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pcnt <= '0;
        else if (!run)         pcnt <= '0;
        else if (pcnt == LAST) pcnt <= '0;
        else                   pcnt <= pcnt + ONE;
      end

      assign tick = run && (pcnt == LAST);

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/cmg_period_ctr.sv
module cmg_period_ctr
  import cmg_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [VAL_W-1:0] mark_val,
  input  logic [VAL_W-1:0] space_val,
  output cmg_phase_e       phase,
  output logic             eoc_pulse
);
  localparam int CW = VAL_W + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0]    cnt;
  logic [VAL_W-1:0] shadow;
  logic             end_phase;

  assign end_phase = tick && (cnt == '0);
  assign eoc_pulse = end_phase &&
                     ((phase == PH_SPACE) || ((phase == PH_MARK) && (shadow == '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      shadow <= '0;
    end else if (phase == PH_IDLE) begin
      if (en) begin
        phase  <= PH_MARK;
        cnt    <= {1'b0, mark_val};
        shadow <= space_val;
      end
    end else if (tick) begin
      if (cnt != '0) begin
        cnt <= cnt - ONE;
      end else if (eoc_pulse) begin
        if (en) begin
          phase  <= PH_MARK;
          cnt    <= {1'b0, mark_val};
          shadow <= space_val;
        end else begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      end else begin
        phase <= PH_SPACE;
        cnt   <= {1'b0, shadow} - ONE;
      end
    end
  end

  AST_SPACE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SPACE) |-> (shadow != '0)); // R3
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_IDLE) && !tick) |=> ($stable(cnt) && $stable(phase))); // R1
  AST_STOP_AT_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_IDLE) && !eoc_pulse) |=> (phase != PH_IDLE)); // R9
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_IDLE) && !eoc_pulse) |=> $stable(shadow)); // R6
endmodule

// File: rtl/cmg_gate.sv
module cmg_gate
  import cmg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmg_phase_e phase,
  input  logic       carrier_in,
  input  logic       baseband,
  input  logic       eoc_pulse,
  input  logic       eoc_clr,
  input  logic       eoc_ie,
  output logic       mod_out,
  output logic       eoc_flag,
  output logic       irq
);
  always_comb begin
    mod_out = 1'b0;
    if (phase == PH_MARK) mod_out = baseband ? 1'b1 : carrier_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         eoc_flag <= 1'b0;
    else if (eoc_pulse) eoc_flag <= 1'b1;
    else if (eoc_clr)   eoc_flag <= 1'b0;
  end

  assign irq = eoc_flag && eoc_ie;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |=> eoc_flag); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_clr && !eoc_pulse) |=> !eoc_flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_flag && !eoc_clr) |=> eoc_flag); // R8
endmodule

// File: rtl/carrier_modulator.sv
module carrier_modulator
  import cmg_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int DIV   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             baseband,
  input  logic             carrier_in,
  input  logic [VAL_W-1:0] mark_val,
  input  logic [VAL_W-1:0] space_val,
  input  logic             eoc_ie,
  input  logic             eoc_clr,
  output logic             mod_out,
  output logic             eoc_flag,
  output logic             irq
);
  cmg_phase_e phase;
  logic       tick;
  logic       eoc_pulse;

  cmg_prescaler #(.DIV(DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (phase != PH_IDLE),
    .tick  (tick)
  );

  cmg_period_ctr #(.VAL_W(VAL_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tick      (tick),
    .mark_val  (mark_val),
    .space_val (space_val),
    .phase     (phase),
    .eoc_pulse (eoc_pulse)
  );

  cmg_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .carrier_in (carrier_in),
    .baseband   (baseband),
    .eoc_pulse  (eoc_pulse),
    .eoc_clr    (eoc_clr),
    .eoc_ie     (eoc_ie),
    .mod_out    (mod_out),
    .eoc_flag   (eoc_flag),
    .irq        (irq)
  );

  AST_EOC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |-> tick); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !mod_out); // R9
endmodule

// File: tb/test_carrier_modulator.sv
module test_carrier_modulator;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, en = 1'b0, baseband = 1'b0, carrier_in = 1'b0;
  logic [15:0] mark_val = '0, space_val = '0;
  logic        eoc_ie = 1'b0, eoc_clr = 1'b0;
  logic        mod_out, eoc_flag, irq;

  carrier_modulator i_carrier_modulator (
    .clk(clk), .rst_n(rst_n), .en(en), .baseband(baseband),
    .carrier_in(carrier_in), .mark_val(mark_val), .space_val(space_val),
    .eoc_ie(eoc_ie), .eoc_clr(eoc_clr),
    .mod_out(mod_out), .eoc_flag(eoc_flag), .irq(irq)
  );

  int total = 0, bad = 0;
  string sect = "R10";
  bit done = 0;

  // behavioural reference: clocks left in the current phase
  bit m_run = 0, m_mark = 0, m_flag = 0, m_eoc;
  int m_left = 0, m_space = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_mark = 0; m_flag = 0; m_left = 0;
    end else begin
      m_eoc = 0;
      if (!m_run) begin
        if (en) begin
          m_run = 1; m_mark = 1;
          m_left = (int'(mark_val) + 1) * 8; m_space = int'(space_val);
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_mark && m_space != 0) begin
            m_mark = 0; m_left = m_space * 8;
          end else begin
            m_eoc = 1;
            if (en) begin
              m_mark = 1;
              m_left = (int'(mark_val) + 1) * 8; m_space = int'(space_val);
            end else begin
              m_run = 0; m_mark = 0;
            end
          end
        end
      end
      if (m_eoc) m_flag = 1;
      else if (eoc_clr) m_flag = 0;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_out;
    e_out = (m_run && m_mark) ? (baseband ? 1'b1 : carrier_in) : 1'b0;
    chk(sect, "mod_out", mod_out, e_out);
    chk(sect, "eoc_flag", eoc_flag, m_flag);
    chk(sect, "irq", irq, m_flag && eoc_ie);
  end

  // carrier from a stand-in generator: toggles every 3 clocks
  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1 carrier_in = ~carrier_in;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe_clr();
    eoc_clr = 1'b1;
    step(1);
    eoc_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    sect = "R10"; step(4);           // reset state
    rst_n = 1'b1; step(2);
    sect = "R4"; mark_val = 16'd2; space_val = 16'd3; en = 1'b1;
    step(150);
    sect = "R6"; step(5); mark_val = 16'd4; space_val = 16'd1; // mid cycle
    step(13); mark_val = 16'd1; step(200);
    sect = "R3"; space_val = 16'd0; step(100);
    sect = "R5"; baseband = 1'b1; mark_val = 16'd3; space_val = 16'd2; step(120);
    sect = "R8"; eoc_ie = 1'b1;
    for (int i = 0; i < 6; i++) begin step(17); strobe_clr(); end
    for (int i = 0; i < 40; i++) begin strobe_clr(); end      // clear near set edges
    sect = "R7"; eoc_ie = 1'b0; step(60); eoc_ie = 1'b1; step(60); strobe_clr(); step(30);
    sect = "R9"; baseband = 1'b0; step(11); en = 1'b0; step(150);
    en = 1'b1; step(100); en = 1'b0; space_val = 16'd0; step(90); en = 1'b1;
    sect = "R2"; mark_val = 16'd0; space_val = 16'd1; step(80);
    baseband = 1'b1; step(60);
    sect = "R1"; baseband = 1'b0; mark_val = 16'd5; space_val = 16'd5; step(200);
    finish_run();
  end
endmodule